// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status Flags

This block receives asynchronous serial frames on a single line. The line is oversampled 16 times per bit, using an enable pulse from an external baud source. Each frame has a low start bit, eight data bits sent least significant bit first, an optional even or odd parity bit, and one stop bit. A finished byte is placed in a data register and a full flag is raised. Reading the data register lowers that flag.

Errors are sticky. There are three: overrun, parity mismatch and a bad stop bit. While any of them is set, the receiver ignores new start bits. Reception resumes only after software has cleared all three. Software clears a flag by first reading it as 1 and then writing 0 to its bit.

A small register bus gives access to a control register, a status register and the data register. The status register also shows the synchronised line level, so software can tell a break from a single bad frame. Two level outputs follow the full flag and the OR of the error flags.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset the control register reads 0x00. The status register reads 0x10 with the line idle high. Both level outputs are low.
- R2: The control register is at address 0: bit 0 enables reception, bit 1 enables parity, bit 2 selects odd parity (0 = even). It reads back as written in bits 2:0 and 0 above them.
- R3: With `os_tick` high on every clock, each bit lasts 16 clocks. A start bit counts only if the line is still low at its middle sample; a shorter low pulse is discarded. Data bits arrive least significant bit first.
- R4: When a frame's stop bit is sampled and the data register is empty, the byte is loaded into the data register (address 2) and the full flag (status bit 0) is set.
- R5: A bus read of address 2 clears the full flag on the following cycle. No write is needed.
- R6: If a stop bit is sampled while the full flag is still set, the overrun flag (status bit 1) is set. The data register keeps the earlier byte and the new byte is dropped.
- R7: With parity enabled, a parity bit that does not give an even (or, in odd mode, an odd) count of ones over data plus parity sets the parity flag (status bit 2). The byte is still loaded.
- R8: A stop bit sampled as 0 sets the framing flag (status bit 3). The byte is still loaded.
- R9: While any of the three error flags is 1, no new frame is received.
- R10: A write to the status register (address 1) clears an error flag only where the written bit is 0 and the flag has been read as 1 since it was set. Writing 1, or writing 0 before reading the flag, leaves it unchanged.
- R11: With the enable bit at 0, no frame is received. Clearing the enable bit during a frame abandons that frame.
- R12: Status bit 4 shows the line level after a two-stage synchroniser, so a line held low after a framing error reads 0.
- R13: `rx_full` follows the full flag, and `rx_err` is the OR of the overrun, parity and framing flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial receive line |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| rx_full | output | 1 | Data register holds an unread byte |
| rx_err | output | 1 | Any error flag set |

## Verification
When the line falls, the byte, full flag and error flags all change at the 155th rising edge (171st with parity), counting the first edge after the fall as the first. The bench's reference model schedules its frame update for exactly that edge. Read data is combinational and is sampled 1 ns after the negative edge that drives the access. The side effects of the access (full clear, flag clear, read-as-1 marking, enable change) occur at the next rising edge. The level outputs are compared with the model at every negative edge, and status is read only once the line has been steady for more than two cycles.

// File: rtl/uart_rx_flags.sv
`timescale 1ns/1ps
module uart_rx_flags #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rx_full,
  output logic       rx_err
);
  localparam int CW = $clog2(OS);
  localparam logic [CW-1:0] MID  = CW'(OS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OS - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;

  st_t st;
  logic s1, rxs;
  logic [CW-1:0] cnt;
  logic [2:0] bidx;
  logic [7:0] sh, dreg;
  logic pbit, en, pen, podd;
  logic full, ovr, perr, ferr;
  logic [2:0] seen;

  wire rd_stat  = bus_sel & ~bus_we & (bus_addr == 2'd1);
  wire rd_data  = bus_sel & ~bus_we & (bus_addr == 2'd2);
  wire wr_ctrl  = bus_sel &  bus_we & (bus_addr == 2'd0);
  wire wr_stat  = bus_sel &  bus_we & (bus_addr == 2'd1);
  wire anyerr   = ovr | perr | ferr;
  wire commit   = os_tick & (st == STOP) & (cnt == LAST);
  wire par_bad  = pen & (pbit ^ (^sh) ^ podd);
  logic unused_hi;
  assign unused_hi = ^bus_wdata[7:4];

  assign rx_full = full;
  assign rx_err  = anyerr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1  <= 1'b1;
      rxs <= 1'b1;
    end else begin
      s1  <= rxd;
      rxs <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= '0;
      bidx <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else if (!en) begin
      st  <= IDLE;
      cnt <= '0;
    end else if (os_tick) begin
      case (st)
        IDLE: if (!rxs && !anyerr) begin
          st  <= START;
          cnt <= '0;
        end
        START: if (cnt == MID) begin
          st   <= rxs ? IDLE : DATA;
          cnt  <= '0;
          bidx <= '0;
        end else cnt <= cnt + 1'b1;
        DATA: if (cnt == LAST) begin
          sh   <= {rxs, sh[7:1]};
          cnt  <= '0;
          bidx <= bidx + 1'b1;
          if (bidx == 3'd7) st <= pen ? PAR : STOP;
        end else cnt <= cnt + 1'b1;
        PAR: if (cnt == LAST) begin
          pbit <= rxs;
          st   <= STOP;
          cnt  <= '0;
        end else cnt <= cnt + 1'b1;
        STOP: if (cnt == LAST) begin
          st  <= IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      pen  <= 1'b0;
      podd <= 1'b0;
    end else if (wr_ctrl) begin
      en   <= bus_wdata[0];
      pen  <= bus_wdata[1];
      podd <= bus_wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreg <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
      seen <= '0;
    end else begin
      if (commit) begin
        if (full) ovr <= 1'b1;
        else begin
          dreg <= sh;
          full <= 1'b1;
          perr <= perr | par_bad;
          ferr <= ferr | ~rxs;
        end
      end else if (rd_data) full <= 1'b0;
      if (rd_stat) seen <= seen | {ferr, perr, ovr};
      if (wr_stat) begin
        if (seen[0] && !bus_wdata[1]) begin ovr  <= 1'b0; seen[0] <= 1'b0; end
        if (seen[1] && !bus_wdata[2]) begin perr <= 1'b0; seen[1] <= 1'b0; end
        if (seen[2] && !bus_wdata[3]) begin ferr <= 1'b0; seen[2] <= 1'b0; end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {5'b0, podd, pen, en};
      2'd1:    bus_rdata = {3'b0, rxs, ferr, perr, ovr, full};
      2'd2:    bus_rdata = dreg;
      default: bus_rdata = 8'h00;
    endcase
  end

  // R4
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(st == STOP));
  // R5
  full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(rd_data));
  // R6
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($stable(dreg) && full));
  // R9
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && anyerr) |=> st == IDLE);
  // R10
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ovr) || $fell(perr) || $fell(ferr)) |-> $past(wr_stat));
  // R11
  en_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> st == IDLE);
endmodule

// File: tb/tb_uart_rx_flags.sv
`timescale 1ns/1ps
module tb_uart_rx_flags;
  logic clk = 0, rst_n = 0, os_tick = 1, rxd = 1, sel = 0, we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  wire [7:0] rdata;
  wire full_o, err_o;

  uart_rx_flags dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .rx_full(full_o), .rx_err(err_o)
  );

  always #5 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;
  bit m_en = 0, m_pen = 0, m_odd = 0, m_full = 0, m_ovr = 0, m_perr = 0, m_ferr = 0;
  bit [2:0] m_seen = 0;
  logic [7:0] m_data = 0;
  int pend_cyc = -1;
  logic [7:0] pend_d;
  bit pend_bad, pend_stop;

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] stat_exp();
    return {3'b0, rxd, m_ferr, m_perr, m_ovr, m_full};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst_n && sel && !we) begin
      if (addr == 2'd1) m_seen = m_seen | {m_ferr, m_perr, m_ovr};
      if (addr == 2'd2) m_full = 0;
    end
    if (rst_n && sel && we) begin
      if (addr == 2'd0) begin
        m_en = wdata[0]; m_pen = wdata[1]; m_odd = wdata[2];
        if (!m_en) pend_cyc = -1;
      end
      if (addr == 2'd1) begin
        if (m_seen[0] && !wdata[1]) begin m_ovr = 0;  m_seen[0] = 0; end
        if (m_seen[1] && !wdata[2]) begin m_perr = 0; m_seen[1] = 0; end
        if (m_seen[2] && !wdata[3]) begin m_ferr = 0; m_seen[2] = 0; end
      end
    end
    if (cyc == pend_cyc) begin
      pend_cyc = -1;
      if (m_full) m_ovr = 1;
      else begin
        m_data = pend_d; m_full = 1;
        if (pend_bad) m_perr = 1;
        if (!pend_stop) m_ferr = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({7'b0, full_o}, {7'b0, m_full}, "R13 full level");
      chk({7'b0, err_o}, {7'b0, m_ovr | m_perr | m_ferr}, "R13 error level");
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    #1 chk(rdata, exp, tag);
    @(negedge clk);
    sel = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic pb, input logic stopb, input bit hold);
    int n;
    bit p;
    @(negedge clk);
    n = cyc;
    p = m_pen;
    if (m_en && !(m_ovr || m_perr || m_ferr)) begin
      pend_cyc  = n + 27 + 16 * (p ? 9 : 8);
      pend_d    = d;
      pend_bad  = p && (pb != ((^d) ^ m_odd));
      pend_stop = stopb;
    end
    rxd = 0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (16) @(negedge clk);
    end
    if (p) begin
      rxd = pb;
      repeat (16) @(negedge clk);
    end
    rxd = stopb;
    repeat (16) @(negedge clk);
    if (!hold) rxd = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({6'b0, full_o, err_o}, 8'h00, "R1 outputs in reset");
    rst_n = 1;
    rd(2'd0, 8'h00, "R1 control after reset");
    rd(2'd1, 8'h10, "R1 status after reset");

    wr(2'd0, 8'h01);
    rd(2'd0, 8'h01, "R2 control readback");
    send(8'hB1, 0, 1, 0);
    rd(2'd1, stat_exp(), "R4 full after frame");
    rd(2'd2, 8'hB1, "R3 byte order lsb first");
    rd(2'd1, stat_exp(), "R5 full cleared by data read");

    send(8'h3C, 0, 1, 0);
    send(8'h5A, 0, 1, 0);
    rd(2'd1, stat_exp(), "R6 overrun flagged");
    rd(2'd2, 8'h3C, "R6 earlier byte kept");
    send(8'h11, 0, 1, 0);
    rd(2'd1, stat_exp(), "R9 blocked while overrun");
    rd(2'd2, 8'h3C, "R9 data unchanged while blocked");
    wr(2'd1, 8'hFF);
    rd(2'd1, stat_exp(), "R10 writing one has no effect");
    wr(2'd1, 8'h00);
    rd(2'd1, stat_exp(), "R10 overrun cleared");
    chk({7'b0, m_ovr}, 8'h00, "R10 model overrun cleared");

    wr(2'd0, 8'h03);
    rd(2'd0, 8'h03, "R2 parity enable readback");
    send(8'h07, 1, 1, 0);
    rd(2'd1, stat_exp(), "R7 even parity good");
    rd(2'd2, 8'h07, "R7 even parity data");
    send(8'h07, 0, 1, 0);
    rd(2'd1, stat_exp(), "R7 even parity error");
    rd(2'd2, 8'h07, "R7 byte loaded despite parity error");
    wr(2'd1, 8'h00);
    rd(2'd1, stat_exp(), "R10 parity flag cleared");
    wr(2'd0, 8'h07);
    send(8'h07, 0, 1, 0);
    rd(2'd1, stat_exp(), "R7 odd parity good");
    rd(2'd2, 8'h07, "R7 odd parity data");

    wr(2'd0, 8'h01);
    send(8'h81, 0, 0, 0);
    wr(2'd1, 8'h00);
    rd(2'd1, stat_exp(), "R10 clear without prior read ignored");
    chk({7'b0, m_ferr}, 8'h01, "R8 framing flag set");
    send(8'h42, 0, 1, 0);
    rd(2'd2, 8'h81, "R8 byte loaded and R9 next frame blocked");
    wr(2'd1, 8'h00);
    rd(2'd1, stat_exp(), "R10 framing flag cleared");

    send(8'h00, 0, 0, 1);
    repeat (5) @(negedge clk);
    rd(2'd1, stat_exp(), "R12 break line reads low");
    rxd = 1;
    repeat (5) @(negedge clk);
    rd(2'd1, stat_exp(), "R12 line high again");
    rd(2'd2, 8'h00, "R8 break byte");
    rd(2'd1, stat_exp(), "R8 status before clear");
    wr(2'd1, 8'h00);

    @(negedge clk);
    rxd = 0;
    repeat (4) @(negedge clk);
    rxd = 1;
    repeat (40) @(negedge clk);
    rd(2'd1, stat_exp(), "R3 short start pulse rejected");

    wr(2'd0, 8'h00);
    send(8'h55, 0, 1, 0);
    rd(2'd1, stat_exp(), "R11 disabled receives nothing");
    wr(2'd0, 8'h01);
    fork
      send(8'h66, 0, 1, 0);
      begin
        repeat (60) @(negedge clk);
        wr(2'd0, 8'h00);
      end
    join
    rd(2'd1, stat_exp(), "R11 frame abandoned on disable");
    rd(2'd2, 8'h00, "R11 data unchanged after abort");
    wr(2'd0, 8'h01);
    send(8'hC3, 0, 1, 0);
    rd(2'd2, 8'hC3, "R4 reception resumes");
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule